// File: doc/BRIEF.md
# Abstract Register Command Engine for Hart Debug

This block sits inside an external debug module and carries out access-register abstract commands against a single hart. A debugger writes a 32-bit command word. The engine screens the word for type, size and hart state. It then runs one register read or write to the core over a single-beat request/response bus, where the request address is the register number. A 32-bit data staging register holds the value to send to the core or the value that came back from it.

The engine keeps a sticky three-bit command error code. Any bit of the code is cleared by writing a one to that bit. While the code is non-zero, new commands are dropped. The engine also holds the halt request that goes to the core and shows the hart's halted state in a halt summary word. After a successful access it can step the register number by one. It also emits a one-cycle post-execute request, which a separate unit uses to run a program buffer.

Top module: `dbg_abs_engine`

## Requirements
- R1: After reset, `cmd_err` is 0, `cmd_busy` is 0, `reg_valid`, `reg_read`, `reg_write`, `postexec_req` and `core_halt_req` are 0, and `data_rd` and `cur_regno` are 0.
- R2: A command word whose type field (bits 31:24) is not 0, whose size field (bits 22:20) is not 2, or whose bit 23 is set sets `cmd_err` to 2 (unsupported). No bus request is issued.
- R3: A command that passes the R2 screen while `hart_halted` is 0 sets `cmd_err` to 4 and issues no bus request.
- R4: An accepted command with the transfer bit (17) set and the write bit (16) set raises `reg_valid` with `reg_write` for exactly the one cycle after the command write. In that cycle `reg_addr` is the low REGNO_W bits of bits 15:0 and `reg_wdata` is the staged data. `cmd_busy` stays 1 until a response is received.
- R5: An accepted command with transfer set and write clear raises `reg_valid` with `reg_read`. A fault-free response loads `reg_rsp_data` into `data_rd` on the response edge.
- R6: An accepted command with transfer clear issues no bus request, ignores the write bit, leaves `cmd_busy` at 0 and leaves `cmd_err` at 0.
- R7: With post-increment (bit 19) set, `cur_regno` rises by one, wrapping at 2^REGNO_W, after a fault-free response. It is unchanged after a faulty response or a transfer-free command.
- R8: A response with `reg_rsp_fault` set sets `cmd_err` to 5 and leaves `data_rd` unchanged.
- R9: A command write while a transfer is outstanding sets `cmd_err` to 1. The outstanding transfer still completes normally.
- R10: While `cmd_err` is non-zero, command writes are dropped: no request is issued, and `cmd_err` and `cur_regno` keep their values.
- R11: A write on `err_clr_en` clears exactly the `cmd_err` bits set in `err_clr_mask`. The other bits hold.
- R12: `core_halt_req` takes the value of `ctl_haltreq` on each `ctl_wr_en` write. `halt_summary` bit 0 equals `hart_halted` and bits 31:1 are 0.
- R13: With post-execute (bit 18) set, `postexec_req` pulses for one cycle after successful completion. That is the response edge, or the command edge when transfer is clear. There is no pulse on any error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr_en | input | 1 | Command register write strobe |
| cmd_wr_data | input | 32 | Command word |
| err_clr_en | input | 1 | Error-clear write strobe |
| err_clr_mask | input | 3 | Ones clear matching error bits |
| data_wr_en | input | 1 | Staging data write strobe |
| data_wr_val | input | DATA_W | Staging data write value |
| data_rd | output | DATA_W | Staging data register |
| cmd_err | output | 3 | Sticky command error code |
| cmd_busy | output | 1 | Transfer outstanding |
| ctl_wr_en | input | 1 | Halt-control write strobe |
| ctl_haltreq | input | 1 | Halt request value |
| hart_halted | input | 1 | Hart is halted |
| core_halt_req | output | 1 | Halt request to the core |
| halt_summary | output | 32 | Halt summary word |
| reg_valid | output | 1 | Register access request |
| reg_addr | output | REGNO_W | Register number |
| reg_read | output | 1 | Request is a read |
| reg_write | output | 1 | Request is a write |
| reg_wdata | output | DATA_W | Write data |
| reg_rsp_valid | input | 1 | Core response valid |
| reg_rsp_fault | input | 1 | Core response reports a fault |
| reg_rsp_data | input | DATA_W | Core read data |
| cur_regno | output | REGNO_W | Current register number |
| postexec_req | output | 1 | One-cycle post-execute request |

## Verification
The bench builds the engine with REGNO_W set to 4. This keeps the register space at sixteen entries, so every register number can be swept for both reads and writes, and post-increment wraparound from 15 to 0 can be reached directly. DATA_W stays 32, matching the only supported access size. All eight size codes and several non-zero type codes are swept, and core response latencies of one to three cycles are mixed in. This exercises the busy window and a command that collides with an outstanding transfer.

// File: rtl/dbg_abs_pkg.sv
package dbg_abs_pkg;

    localparam logic [7:0] KIND_REG_ACCESS = 8'd0;
    localparam logic [2:0] WIDTH_CODE_32   = 3'd2;

    typedef enum logic [2:0] {
        AE_NONE    = 3'd0,
        AE_BUSY    = 3'd1,
        AE_UNSUP   = 3'd2,
        AE_EXCEPT  = 3'd3,
        AE_NOTHALT = 3'd4,
        AE_BUS     = 3'd5,
        AE_RSVD    = 3'd6,
        AE_OTHER   = 3'd7
    } abs_err_e;

    typedef struct packed {
        logic [7:0]  kind;
        logic        rsvd;
        logic [2:0]  width_code;
        logic        step_after;
        logic        run_after;
        logic        move;
        logic        to_reg;
        logic [15:0] regnum;
    } abs_cmd_t;

    typedef enum logic [1:0] {
        XS_IDLE = 2'd0,
        XS_REQ  = 2'd1,
        XS_WAIT = 2'd2
    } xfer_state_e;

    function automatic abs_err_e screen_cmd(abs_cmd_t c, logic halted);
        if (c.kind != KIND_REG_ACCESS || c.rsvd || c.width_code != WIDTH_CODE_32)
            return AE_UNSUP;
        else if (!halted)
            return AE_NOTHALT;
        else
            return AE_NONE;
    endfunction

endpackage

// File: rtl/dbg_err_latch.sv
module dbg_err_latch
    import dbg_abs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       set_en,
    input  logic [2:0] set_code,
    input  logic       clr_en,
    input  logic [2:0] clr_mask,
    output logic [2:0] err_q
);

    always_ff @(posedge clk) begin
        if (rst)
            err_q <= AE_NONE;
        else if (set_en && err_q == AE_NONE)
            err_q <= set_code;
        else if (clr_en)
            err_q <= err_q & ~clr_mask;
    end

    // R11: a non-zero code only moves through an explicit clear
    assert_err_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        (err_q != AE_NONE && !clr_en) |=> (err_q == $past(err_q)));

    // R11: a clear never sets a bit that was zero
    assert_clr_no_set_R11: assert property (@(posedge clk) disable iff (rst)
        (clr_en && !set_en) |=> ((err_q & ~$past(err_q)) == 3'd0));

endmodule

// File: rtl/dbg_xfer_fsm.sv
module dbg_xfer_fsm
    import dbg_abs_pkg::*;
#(
    parameter int REGNO_W = 16,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               start_move,
    input  logic               start_to_reg,
    input  logic               start_step,
    input  logic               start_run,
    input  logic [REGNO_W-1:0] start_regnum,
    input  logic               data_wr_en,
    input  logic [DATA_W-1:0]  data_wr_val,
    input  logic               rsp_valid,
    input  logic               rsp_fault,
    input  logic [DATA_W-1:0]  rsp_data,
    output logic               busy,
    output logic               fault_evt,
    output logic               req_valid,
    output logic               req_read,
    output logic               req_write,
    output logic [REGNO_W-1:0] regnum,
    output logic [DATA_W-1:0]  stage_data,
    output logic               run_pulse
);

    localparam logic [REGNO_W-1:0] REG_STEP = REGNO_W'(1);

    xfer_state_e state;
    logic        op_to_reg;
    logic        op_step;
    logic        op_run;
    logic        rsp_take;

    assign rsp_take  = (state == XS_WAIT) && rsp_valid;
    assign fault_evt = rsp_take && rsp_fault;
    assign busy      = (state != XS_IDLE);
    assign req_valid = (state == XS_REQ);
    assign req_read  = req_valid && !op_to_reg;
    assign req_write = req_valid && op_to_reg;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= XS_IDLE;
            op_to_reg  <= 1'b0;
            op_step    <= 1'b0;
            op_run     <= 1'b0;
            regnum     <= '0;
            stage_data <= '0;
            run_pulse  <= 1'b0;
        end else begin
            run_pulse <= 1'b0;
            unique case (state)
                XS_IDLE: begin
                    if (start) begin
                        regnum    <= start_regnum;
                        op_to_reg <= start_to_reg;
                        op_step   <= start_step;
                        op_run    <= start_run;
                        if (start_move)
                            state <= XS_REQ;
                        else
                            run_pulse <= start_run;
                    end else if (data_wr_en) begin
                        stage_data <= data_wr_val;
                    end
                end
                XS_REQ: state <= XS_WAIT;
                XS_WAIT: begin
                    if (rsp_take) begin
                        state <= XS_IDLE;
                        if (!rsp_fault) begin
                            if (!op_to_reg)
                                stage_data <= rsp_data;
                            if (op_step)
                                regnum <= regnum + REG_STEP;
                            run_pulse <= op_run;
                        end
                    end
                end
                default: state <= XS_IDLE;
            endcase
        end
    end

    // R4: a request lasts exactly one cycle
    assert_req_single_R4: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> !req_valid);

    // R13: post-execute request is a single-cycle pulse
    assert_run_single_R13: assert property (@(posedge clk) disable iff (rst)
        run_pulse |=> !run_pulse);

    // R8: a faulty response leaves the staging data untouched
    assert_fault_keeps_data_R8: assert property (@(posedge clk) disable iff (rst)
        fault_evt |=> $stable(stage_data));

endmodule

// File: rtl/dbg_abs_engine.sv
module dbg_abs_engine
    import dbg_abs_pkg::*;
#(
    parameter int REGNO_W = 16,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_wr_en,
    input  logic [31:0]        cmd_wr_data,
    input  logic               err_clr_en,
    input  logic [2:0]         err_clr_mask,
    input  logic               data_wr_en,
    input  logic [DATA_W-1:0]  data_wr_val,
    output logic [DATA_W-1:0]  data_rd,
    output logic [2:0]         cmd_err,
    output logic               cmd_busy,
    input  logic               ctl_wr_en,
    input  logic               ctl_haltreq,
    input  logic               hart_halted,
    output logic               core_halt_req,
    output logic [31:0]        halt_summary,
    output logic               reg_valid,
    output logic [REGNO_W-1:0] reg_addr,
    output logic               reg_read,
    output logic               reg_write,
    output logic [DATA_W-1:0]  reg_wdata,
    input  logic               reg_rsp_valid,
    input  logic               reg_rsp_fault,
    input  logic [DATA_W-1:0]  reg_rsp_data,
    output logic [REGNO_W-1:0] cur_regno,
    output logic               postexec_req
);

    abs_cmd_t     cmd;
    abs_err_e     verdict;
    logic         busy;
    logic         fault_evt;
    logic         cmd_live;
    logic         accept;
    logic         err_set;
    logic [2:0]   err_code;
    logic         halt_q;
    logic [REGNO_W-1:0] regnum;
    logic [DATA_W-1:0]  stage_data;

    assign cmd      = abs_cmd_t'(cmd_wr_data);
    assign verdict  = screen_cmd(cmd, hart_halted);
    assign cmd_live = cmd_wr_en && (cmd_err == AE_NONE);
    assign accept   = cmd_live && !busy && (verdict == AE_NONE);

    always_comb begin
        err_set  = 1'b0;
        err_code = AE_NONE;
        if (fault_evt) begin
            err_set  = 1'b1;
            err_code = AE_BUS;
        end else if (cmd_live && busy) begin
            err_set  = 1'b1;
            err_code = AE_BUSY;
        end else if (cmd_live && verdict != AE_NONE) begin
            err_set  = 1'b1;
            err_code = verdict;
        end
    end

    dbg_err_latch u_err (
        .clk      (clk),
        .rst      (rst),
        .set_en   (err_set),
        .set_code (err_code),
        .clr_en   (err_clr_en),
        .clr_mask (err_clr_mask),
        .err_q    (cmd_err)
    );

    dbg_xfer_fsm #(
        .REGNO_W (REGNO_W),
        .DATA_W  (DATA_W)
    ) u_xfer (
        .clk          (clk),
        .rst          (rst),
        .start        (accept),
        .start_move   (cmd.move),
        .start_to_reg (cmd.to_reg),
        .start_step   (cmd.step_after),
        .start_run    (cmd.run_after),
        .start_regnum (cmd.regnum[REGNO_W-1:0]),
        .data_wr_en   (data_wr_en),
        .data_wr_val  (data_wr_val),
        .rsp_valid    (reg_rsp_valid),
        .rsp_fault    (reg_rsp_fault),
        .rsp_data     (reg_rsp_data),
        .busy         (busy),
        .fault_evt    (fault_evt),
        .req_valid    (reg_valid),
        .req_read     (reg_read),
        .req_write    (reg_write),
        .regnum       (regnum),
        .stage_data   (stage_data),
        .run_pulse    (postexec_req)
    );

    always_ff @(posedge clk) begin
        if (rst)
            halt_q <= 1'b0;
        else if (ctl_wr_en)
            halt_q <= ctl_haltreq;
    end

    assign core_halt_req = halt_q;
    assign halt_summary  = {31'd0, hart_halted};
    assign cmd_busy      = busy;
    assign reg_addr      = regnum;
    assign cur_regno     = regnum;
    assign reg_wdata     = stage_data;
    assign data_rd       = stage_data;

    // R3: every request follows a command taken while the hart was halted
    assert_req_after_halt_R3: assert property (@(posedge clk) disable iff (rst)
        reg_valid |-> $past(hart_halted));

    // R10: a command dropped for a pending error starts nothing
    assert_drop_on_err_R10: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr_en && cmd_err != 3'd0 && !busy && !err_clr_en)
        |=> (!reg_valid && cmd_err == $past(cmd_err)));

    // R9: a colliding command leaves the outstanding transfer running
    assert_collide_keeps_busy_R9: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr_en && busy && !reg_rsp_valid) |=> busy);

endmodule

// File: tb/sim_dbg_abs_engine.sv
module sim_dbg_abs_engine;

    localparam int CLK_PERIOD = 10;
    localparam int RW = 4;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_wr_en = 1'b0;
    logic [31:0]   cmd_wr_data = '0;
    logic          err_clr_en = 1'b0;
    logic [2:0]    err_clr_mask = '0;
    logic          data_wr_en = 1'b0;
    logic [DW-1:0] data_wr_val = '0;
    logic [DW-1:0] data_rd;
    logic [2:0]    cmd_err;
    logic          cmd_busy;
    logic          ctl_wr_en = 1'b0;
    logic          ctl_haltreq = 1'b0;
    logic          hart_halted = 1'b0;
    logic          core_halt_req;
    logic [31:0]   halt_summary;
    logic          reg_valid;
    logic [RW-1:0] reg_addr;
    logic          reg_read;
    logic          reg_write;
    logic [DW-1:0] reg_wdata;
    logic          reg_rsp_valid = 1'b0;
    logic          reg_rsp_fault = 1'b0;
    logic [DW-1:0] reg_rsp_data = '0;
    logic [RW-1:0] cur_regno;
    logic          postexec_req;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbg_abs_engine #(.REGNO_W(RW), .DATA_W(DW)) u0 (.*);

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [7:0] kind, input logic [2:0] sz,
                                       input logic step, input logic run, input logic mv,
                                       input logic wr, input logic [15:0] rn);
        return {kind, 1'b0, sz, step, run, mv, wr, rn};
    endfunction

    task automatic send_cmd(input logic [31:0] w);
        @(negedge clk); cmd_wr_en = 1'b1; cmd_wr_data = w;
        @(negedge clk); cmd_wr_en = 1'b0;
    endtask

    task automatic set_data(input logic [31:0] v);
        @(negedge clk); data_wr_en = 1'b1; data_wr_val = v;
        @(negedge clk); data_wr_en = 1'b0;
    endtask

    task automatic clear_err(input logic [2:0] m);
        @(negedge clk); err_clr_en = 1'b1; err_clr_mask = m;
        @(negedge clk); err_clr_en = 1'b0;
    endtask

    // called at the negedge where reg_valid is high
    task automatic respond(input int lat, input logic flt, input logic [31:0] d);
        repeat (lat) begin
            @(negedge clk);
            check({31'd0, cmd_busy}, 32'd1, "R4 busy while waiting");
        end
        reg_rsp_valid = 1'b1; reg_rsp_fault = flt; reg_rsp_data = d;
        @(negedge clk);
        reg_rsp_valid = 1'b0; reg_rsp_fault = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check({29'd0, cmd_err}, 0, "R1 err");
        check({31'd0, cmd_busy}, 0, "R1 busy");
        check({28'd0, reg_valid, reg_read, reg_write, postexec_req}, 0, "R1 bus");
        check({31'd0, core_halt_req}, 0, "R1 halt");
        check(data_rd, 0, "R1 data");
        check({28'd0, cur_regno}, 0, "R1 regno");

        // R12 halt control and summary
        @(negedge clk); ctl_wr_en = 1'b1; ctl_haltreq = 1'b1;
        @(negedge clk); ctl_wr_en = 1'b0;
        check({31'd0, core_halt_req}, 1, "R12 halt set");
        check(halt_summary, 32'd0, "R12 summary running");

        // R3 not halted
        send_cmd(mk(8'd0, 3'd2, 1'b0, 1'b0, 1'b1, 1'b0, 16'd3));
        check({29'd0, cmd_err}, 4, "R3 err");
        check({31'd0, reg_valid}, 0, "R3 no request");
        // R11 partial clear leaves bit 2
        clear_err(3'b011);
        check({29'd0, cmd_err}, 4, "R11 partial clear");
        // R10 dropped while error set
        hart_halted = 1'b1;
        send_cmd(mk(8'd0, 3'd2, 1'b0, 1'b0, 1'b1, 1'b0, 16'd9));
        check({31'd0, reg_valid}, 0, "R10 no request");
        check({29'd0, cmd_err}, 4, "R10 err held");
        check({28'd0, cur_regno}, 0, "R10 regno held");
        clear_err(3'b100);
        check({29'd0, cmd_err}, 0, "R11 cleared");
        @(negedge clk);
        check(halt_summary, 32'd1, "R12 summary halted");
        @(negedge clk); ctl_wr_en = 1'b1; ctl_haltreq = 1'b0;
        @(negedge clk); ctl_wr_en = 1'b0;
        check({31'd0, core_halt_req}, 0, "R12 halt cleared");

        // R2 size sweep
        for (int s = 0; s < 8; s++) begin
            if (s != 2) begin
                send_cmd(mk(8'd0, 3'(s), 1'b0, 1'b0, 1'b1, 1'b1, 16'd1));
                check({29'd0, cmd_err}, 2, "R2 size");
                check({31'd0, reg_valid}, 0, "R2 size no request");
                clear_err(3'b111);
            end
        end
        // R2 kind sweep
        for (int k = 1; k < 256; k = k * 3) begin
            send_cmd(mk(8'(k), 3'd2, 1'b0, 1'b0, 1'b1, 1'b1, 16'd1));
            check({29'd0, cmd_err}, 2, "R2 kind");
            clear_err(3'b111);
        end
        send_cmd(mk(8'd0, 3'd2, 1'b0, 1'b0, 1'b1, 1'b1, 16'd1) | 32'h0080_0000);
        check({29'd0, cmd_err}, 2, "R2 reserved bit");
        clear_err(3'b111);

        // R4 write sweep over every register
        for (int r = 0; r < 16; r++) begin
            logic [31:0] wv;
            wv = 32'h5A00_0000 ^ (32'(r) * 32'h0101_0101);
            set_data(wv);
            send_cmd(mk(8'd0, 3'd2, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0100 | 16'(r)));
            check({29'd0, reg_valid, reg_write, reg_read}, 3'b110, "R4 write request");
            check({28'd0, reg_addr}, 32'(r), "R4 addr");
            check(reg_wdata, wv, "R4 wdata");
            respond(1 + (r % 3), 1'b0, 32'hDEAD_BEEF);
            check({31'd0, cmd_busy}, 0, "R4 done");
            check(data_rd, wv, "R4 data kept on write");
            check({29'd0, cmd_err}, 0, "R4 no err");
        end

        // R5 read sweep
        for (int r = 0; r < 16; r++) begin
            logic [31:0] rv;
            rv = (32'(r) << 24) + 32'h0013_3700 + 32'(r * 7);
            send_cmd(mk(8'd0, 3'd2, 1'b0, 1'b0, 1'b1, 1'b0, 16'(r)));
            check({29'd0, reg_valid, reg_write, reg_read}, 3'b101, "R5 read request");
            check({28'd0, reg_addr}, 32'(r), "R5 addr");
            respond(1 + ((r + 1) % 3), 1'b0, rv);
            check(data_rd, rv, "R5 data loaded");
        end

        // R7 post-increment with wrap, and R13 pulse after response
        send_cmd(mk(8'd0, 3'd2, 1'b1, 1'b1, 1'b1, 1'b0, 16'd15));
        respond(2, 1'b0, 32'h1111_2222);
        check({28'd0, cur_regno}, 0, "R7 wrap");
        check({31'd0, postexec_req}, 1, "R13 pulse");
        @(negedge clk);
        check({31'd0, postexec_req}, 0, "R13 pulse ends");
        send_cmd(mk(8'd0, 3'd2, 1'b1, 1'b0, 1'b1, 1'b1, 16'd5));
        respond(1, 1'b0, 32'h0);
        check({28'd0, cur_regno}, 6, "R7 step");

        // R8 fault: no data load, no step, no pulse
        set_data(32'hCAFE_F00D);
        send_cmd(mk(8'd0, 3'd2, 1'b1, 1'b1, 1'b1, 1'b0, 16'd7));
        respond(1, 1'b1, 32'h9999_9999);
        check({29'd0, cmd_err}, 5, "R8 err");
        check(data_rd, 32'hCAFE_F00D, "R8 data kept");
        check({28'd0, cur_regno}, 7, "R7 no step on fault");
        check({31'd0, postexec_req}, 0, "R13 no pulse on fault");
        clear_err(3'b101);
        check({29'd0, cmd_err}, 0, "R11 clear bus err");

        // R9 collision while waiting
        send_cmd(mk(8'd0, 3'd2, 1'b0, 1'b0, 1'b1, 1'b0, 16'd2));
        @(negedge clk); cmd_wr_en = 1'b1;
        cmd_wr_data = mk(8'd0, 3'd2, 1'b0, 1'b0, 1'b1, 1'b1, 16'd4);
        @(negedge clk); cmd_wr_en = 1'b0;
        check({29'd0, cmd_err}, 1, "R9 busy err");
        check({31'd0, cmd_busy}, 1, "R9 still busy");
        reg_rsp_valid = 1'b1; reg_rsp_data = 32'h7777_0001;
        @(negedge clk); reg_rsp_valid = 1'b0;
        check(data_rd, 32'h7777_0001, "R9 transfer completed");
        check({28'd0, cur_regno}, 2, "R9 regno of first");
        clear_err(3'b001);

        // R6 transfer clear: write bit ignored, R13 pulse on command edge
        send_cmd(mk(8'd0, 3'd2, 1'b1, 1'b1, 1'b0, 1'b1, 16'd11));
        check({31'd0, reg_valid}, 0, "R6 no request");
        check({31'd0, cmd_busy}, 0, "R6 not busy");
        check({29'd0, cmd_err}, 0, "R6 no err");
        check({31'd0, postexec_req}, 1, "R13 pulse no transfer");
        check({28'd0, cur_regno}, 11, "R7 no step without transfer");
        @(negedge clk);
        check({31'd0, reg_valid}, 0, "R6 still no request");
        check(data_rd, 32'h7777_0001, "R6 data untouched");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule